// File: doc/BRIEF.md
# Video Memory Access Port

This block lets a processor with an 8-bit register interface read and write a video RAM organised as 16-bit words. The processor first loads a word address through two byte registers. It then streams data through a low-byte data register and a high-byte data register. Each data write goes to the RAM at once, with only its own byte lane enabled, so the other byte of the word stays as it was.

After each access on the chosen byte lane, the address advances automatically by a programmable stride. This makes the same port usable for byte-only uploads and for ordered two-byte word uploads. With the low lane as trigger, software writes the high byte first and the low byte last. With the high lane as trigger, it writes the low byte first and the high byte last.

Reads go through a one-word prefetch latch. Loading the address, or reading the trigger lane, queues a fetch of the current word from the RAM. The fetch waits while the port is using the RAM for a write. The two read registers return the two halves of the latched word.

Top module: `vram_port`

## Requirements
- R1: After reset, the word address is 0, the control register reads 0, the prefetch latch holds 0, and neither `mem_we_o` nor `mem_re_o` is asserted.
- R2: A write to select 1 replaces bits 7:0 of the word address. A write to select 2 replaces bits 15:8. Address bits at or above ADDR_W are discarded. `mem_addr_o` always shows the current word address.
- R3: A write to select 3 drives `mem_we_o` in the same cycle, with `mem_be_o`=01, the byte on both halves of `mem_wdata_o`, and the current address. A write to select 4 does the same with `mem_be_o`=10. In the RAM, only the enabled byte of the word changes.
- R4: Control bit 7 chooses the trigger lane: 0 = the low lane (select 3 write or read), 1 = the high lane (select 4 write or read). An access on the trigger lane advances the address at the end of its cycle. An access on the other lane leaves the address unchanged.
- R5: Control bits 1:0 set the stride: 00 = 1, 01 = 32, 10 = 64, 11 = 128 words.
- R6: A control write stores bits 7, 3:2 and 1:0. Bits 6:4 are stored as 0. Select 0 reads back the stored value. Bits 3:2 have no effect on the address sequence.
- R7: The address wraps modulo 2^ADDR_W when a step passes the last word.
- R8: An address-byte write, or a trigger-lane read, queues a fetch. The fetch appears as `mem_re_o` at the address the port holds when it is issued. Read data arrives one cycle later and is captured into the latch. Select 3 reads the latch's low byte and select 4 its high byte. A read on the non-trigger lane neither steps the address nor fetches.
- R9: If a data write falls in the cycle where a queued fetch would issue, the write goes first and the fetch waits for the next cycle with no write. `mem_we_o` and `mem_re_o` are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 3 | Register select: 0 control, 1 address low, 2 address high, 3 data low, 4 data high |
| reg_wr_i | input | 1 | Register write strobe (one cycle per access) |
| reg_rd_i | input | 1 | Register read strobe (ignored while reg_wr_i is high) |
| reg_wdata_i | input | 8 | Write data byte |
| reg_rdata_o | output | 8 | Read data for the selected register |
| mem_addr_o | output | ADDR_W | RAM word address |
| mem_we_o | output | 1 | RAM write enable |
| mem_be_o | output | 2 | RAM byte enables: bit 0 low byte, bit 1 high byte |
| mem_wdata_o | output | 16 | RAM write word |
| mem_re_o | output | 1 | RAM read request |
| mem_rdata_i | input | 16 | RAM read word, valid one cycle after mem_re_o |

## Verification
A queued prefetch and a data write can compete for the RAM in the same cycle. The bench provokes this by loading the address and writing a data byte in the very next cycle, with the high lane chosen as trigger so the address does not move. It then checks that the write strobe is alone on the RAM port in that cycle and that the read strobe appears in the next cycle at the same address. Finally, the latched word must hold the freshly written low byte next to the untouched high byte, which shows the write was ordered ahead of the fetch.

// File: rtl/vram_port_pkg.sv
package vram_port_pkg;

  typedef enum logic [2:0] {
    SEL_CTRL    = 3'd0,
    SEL_ADDR_LO = 3'd1,
    SEL_ADDR_HI = 3'd2,
    SEL_DATA_LO = 3'd3,
    SEL_DATA_HI = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic       hi_trig;
    logic [2:0] rsvd;
    logic [1:0] fmt;
    logic [1:0] stride;
  } ctrl_t;

  localparam logic [7:0] CTRL_WMASK = 8'h8F;

  function automatic logic [7:0] stride_words(input logic [1:0] code);
    case (code)
      2'd0:    return 8'd1;
      2'd1:    return 8'd32;
      2'd2:    return 8'd64;
      default: return 8'd128;
    endcase
  endfunction

endpackage

// File: rtl/vram_port_ctrl.sv
module vram_port_ctrl
  import vram_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wdata_i,
  output ctrl_t      ctrl_o
);

  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_en_i) ctrl_q <= ctrl_t'(wdata_i & CTRL_WMASK);
  end

  assign ctrl_o = ctrl_q;

  a_r6_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (ctrl_o.rsvd == 3'd0));

endmodule

// File: rtl/vram_port_addr.sv
module vram_port_addr
  import vram_port_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_lo_i,
  input  logic              load_hi_i,
  input  logic [7:0]        byte_i,
  input  logic              step_en_i,
  input  logic [1:0]        stride_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int WIDE_W = 16;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WIDE_W-1:0] wide;

  assign wide = WIDE_W'(addr_q);

  always_comb begin
    addr_d = addr_q;
    if (load_lo_i)      addr_d = ADDR_W'({wide[15:8], byte_i});
    else if (load_hi_i) addr_d = ADDR_W'({byte_i, wide[7:0]});
    else if (step_en_i) addr_d = addr_q + ADDR_W'(stride_words(stride_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_d;
  end

  assign addr_o = addr_q;

  a_r2_lo_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_lo_i |=> (WIDE_W'(addr_o) & 16'h00FF) == (WIDE_W'(ADDR_W'($past(byte_i))) & 16'h00FF));

endmodule

// File: rtl/vram_port_prefetch.sv
module vram_port_prefetch (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        fetch_req_i,
  input  logic        wr_busy_i,
  input  logic [15:0] mem_rdata_i,
  output logic        mem_re_o,
  output logic [15:0] latch_o
);

  logic        pend_q, rvalid_q;
  logic [15:0] latch_q;

  assign mem_re_o = pend_q & ~wr_busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      rvalid_q <= 1'b0;
      latch_q  <= '0;
    end else begin
      pend_q   <= fetch_req_i | (pend_q & ~mem_re_o);
      rvalid_q <= mem_re_o;
      if (rvalid_q) latch_q <= mem_rdata_i;
    end
  end

  assign latch_o = latch_q;

  // R9: a fetch blocked by a write stays queued
  a_r9_fetch_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && wr_busy_i) |=> pend_q);

  a_r8_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mem_re_o) |=> (latch_o == $past(mem_rdata_i)));

endmodule

// File: rtl/vram_port.sv
module vram_port
  import vram_port_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        reg_sel_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [1:0]        mem_be_o,
  output logic [15:0]       mem_wdata_o,
  output logic              mem_re_o,
  input  logic [15:0]       mem_rdata_i
);

  ctrl_t       ctrl;
  logic [15:0] latch;
  logic        wr_ctrl, wr_alo, wr_ahi, wr_dlo, wr_dhi, rd_lo, rd_hi;
  logic        lo_acc, hi_acc, step_en, trig_rd, fetch_req;

  assign wr_ctrl = reg_wr_i && (reg_sel_i == SEL_CTRL);
  assign wr_alo  = reg_wr_i && (reg_sel_i == SEL_ADDR_LO);
  assign wr_ahi  = reg_wr_i && (reg_sel_i == SEL_ADDR_HI);
  assign wr_dlo  = reg_wr_i && (reg_sel_i == SEL_DATA_LO);
  assign wr_dhi  = reg_wr_i && (reg_sel_i == SEL_DATA_HI);
  assign rd_lo   = reg_rd_i && !reg_wr_i && (reg_sel_i == SEL_DATA_LO);
  assign rd_hi   = reg_rd_i && !reg_wr_i && (reg_sel_i == SEL_DATA_HI);

  assign lo_acc    = wr_dlo | rd_lo;
  assign hi_acc    = wr_dhi | rd_hi;
  assign step_en   = ctrl.hi_trig ? hi_acc : lo_acc;
  assign trig_rd   = ctrl.hi_trig ? rd_hi : rd_lo;
  assign fetch_req = wr_alo | wr_ahi | trig_rd;

  vram_port_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_ctrl),
    .wdata_i (reg_wdata_i),
    .ctrl_o  (ctrl)
  );

  vram_port_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_lo_i (wr_alo),
    .load_hi_i (wr_ahi),
    .byte_i    (reg_wdata_i),
    .step_en_i (step_en),
    .stride_i  (ctrl.stride),
    .addr_o    (mem_addr_o)
  );

  vram_port_prefetch u_pf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fetch_req_i (fetch_req),
    .wr_busy_i   (mem_we_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_re_o    (mem_re_o),
    .latch_o     (latch)
  );

  assign mem_we_o    = wr_dlo | wr_dhi;
  assign mem_be_o    = {wr_dhi, wr_dlo};
  assign mem_wdata_o = {reg_wdata_i, reg_wdata_i};

  always_comb begin
    case (reg_sel_i)
      SEL_CTRL:    reg_rdata_o = ctrl;
      SEL_DATA_LO: reg_rdata_o = latch[7:0];
      SEL_DATA_HI: reg_rdata_o = latch[15:8];
      default:     reg_rdata_o = 8'h00;
    endcase
  end

  logic [ADDR_W-1:0] chk_stride;
  always_comb begin
    unique case (ctrl.stride)
      2'b00: chk_stride = ADDR_W'(1);
      2'b01: chk_stride = ADDR_W'(32);
      2'b10: chk_stride = ADDR_W'(64);
      2'b11: chk_stride = ADDR_W'(128);
    endcase
  end

  a_r9_we_re_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  a_r3_single_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ($countones(mem_be_o) == 1));

  a_r8_fetch_or_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_alo || wr_ahi) |=> (mem_re_o || mem_we_o));

  a_r4_other_lane_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i || reg_rd_i) && (ctrl.hi_trig ? (reg_sel_i == SEL_DATA_LO) : (reg_sel_i == SEL_DATA_HI))
    |=> $stable(mem_addr_o));

  a_r5_stride: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i || reg_rd_i) && (ctrl.hi_trig ? (reg_sel_i == SEL_DATA_HI) : (reg_sel_i == SEL_DATA_LO))
    |=> (mem_addr_o == $past(mem_addr_o) + $past(chk_stride)));

endmodule

// File: tb/tb_vram_port.sv
module tb_vram_port;

  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] S_CTRL = 3'd0, S_ALO = 3'd1, S_AHI = 3'd2, S_DLO = 3'd3, S_DHI = 3'd4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    sel = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic [AW-1:0] maddr;
  logic          mwe, mre;
  logic [1:0]    mbe;
  logic [15:0]   mwdata, mrdata;

  logic [15:0] ram [DEPTH];
  int checks = 0, fails = 0;
  logic          p_we, p_re;
  logic [1:0]    p_be;
  logic [AW-1:0] p_addr;
  logic [15:0]   p_wdata;
  logic [7:0]    p_rdata;

  always #5 clk = ~clk;

  vram_port #(.ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_sel_i(sel), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mem_addr_o(maddr), .mem_we_o(mwe),
    .mem_be_o(mbe), .mem_wdata_o(mwdata), .mem_re_o(mre), .mem_rdata_i(mrdata)
  );

  always @(posedge clk) begin
    if (mwe) begin
      if (mbe[0]) ram[maddr][7:0]  <= mwdata[7:0];
      if (mbe[1]) ram[maddr][15:8] <= mwdata[15:8];
    end
    if (mre) mrdata <= ram[maddr];
  end

  function automatic logic [15:0] pat(input int i);
    return 16'(i * 16'h0107) ^ 16'hA5C3;
  endfunction

  function automatic int stride(input int code);
    case (code)
      0: return 1;
      1: return 32;
      2: return 64;
      default: return 128;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // each access task starts and ends on a falling edge and takes one cycle
  task automatic reg_write(input logic [2:0] s, input logic [7:0] d);
    sel = s; wdata = d; wr = 1'b1; rd = 1'b0;
    #1;
    p_we = mwe; p_re = mre; p_be = mbe; p_addr = maddr; p_wdata = mwdata;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] s);
    sel = s; rd = 1'b1; wr = 1'b0;
    #1;
    p_rdata = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] s, output logic [7:0] v);
    sel = s;
    #1;
    v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_addr(input int a);
    reg_write(S_AHI, 8'(a >> 8));
    reg_write(S_ALO, 8'(a));
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 addr", 32'(maddr), 0);
    chk("R1 we", 32'(mwe), 0);
    chk("R1 re", 32'(mre), 0);
    peek(S_CTRL, v); chk("R1 ctrl", 32'(v), 0);
    peek(S_DLO, v);  chk("R1 latch", 32'(v), 0);
  endtask

  task automatic t_load();
    logic [7:0] v;
    reg_write(S_ALO, 8'h34);
    reg_write(S_AHI, 8'h12);
    chk("R2 truncated load", 32'(maddr), 32'h234);
    idle(3);
    peek(S_DLO, v); chk("R8 load fetch lo", 32'(v), 32'(pat(32'h234) & 16'hFF));
    peek(S_DHI, v); chk("R8 load fetch hi", 32'(v), 32'(pat(32'h234) >> 8));
    set_addr(16'hFFFF);
    chk("R2 high bits dropped", 32'(maddr), 32'h3FF);
  endtask

  task automatic t_byte_writes();
    logic [7:0] v;
    reg_write(S_CTRL, 8'h00);
    set_addr(16'h0010);
    reg_write(S_DLO, 8'hAB);
    chk("R3 lo we", 32'(p_we), 1);
    chk("R3 lo be", 32'(p_be), 32'b01);
    chk("R3 lo addr", 32'(p_addr), 32'h10);
    chk("R3 lo wdata", 32'(p_wdata), 32'hABAB);
    chk("R4 lo step", 32'(maddr), 32'h11);
    reg_write(S_DHI, 8'hCD);
    chk("R3 hi be", 32'(p_be), 32'b10);
    chk("R4 hi no step", 32'(maddr), 32'h11);
    set_addr(16'h0010);
    idle(3);
    peek(S_DLO, v); chk("R3 lane written", 32'(v), 32'hAB);
    peek(S_DHI, v); chk("R3 lane kept", 32'(v), 32'(pat(32'h10) >> 8));
  endtask

  task automatic t_word_hi_trig();
    reg_write(S_CTRL, 8'h80);
    set_addr(16'h0020);
    reg_write(S_DLO, 8'h11);
    chk("R4 hi-trig lo hold", 32'(maddr), 32'h20);
    reg_write(S_DHI, 8'h22);
    chk("R4 hi-trig step", 32'(maddr), 32'h21);
    chk("R3 word stored", 32'(ram[32'h20]), 32'h2211);
  endtask

  task automatic t_strides();
    for (int c = 0; c < 4; c++) begin
      reg_write(S_CTRL, 8'(c));
      set_addr(16'h0100);
      reg_write(S_DLO, 8'h00);
      chk($sformatf("R5 stride code %0d", c), 32'(maddr), 32'(32'h100 + stride(c)));
    end
  endtask

  task automatic t_fmt();
    logic [7:0] v;
    reg_write(S_CTRL, 8'hFE);
    peek(S_CTRL, v); chk("R6 readback", 32'(v), 32'h8E);
    set_addr(16'h0200);
    reg_write(S_DHI, 8'h5A);
    chk("R6 fmt no effect", 32'(maddr), 32'h240);
    reg_write(S_DLO, 8'h5B);
    chk("R6 fmt lo hold", 32'(maddr), 32'h240);
  endtask

  task automatic t_wrap();
    reg_write(S_CTRL, 8'h03);
    set_addr(16'h03F0);
    reg_write(S_DLO, 8'h01);
    chk("R7 wrap", 32'(maddr), 32'h070);
  endtask

  task automatic t_reads();
    logic [7:0] v;
    reg_write(S_CTRL, 8'h00);
    set_addr(16'h0040);
    idle(3);
    reg_read(S_DHI);
    chk("R8 non-trig read", 32'(p_rdata), 32'(pat(32'h40) >> 8));
    chk("R4 non-trig read hold", 32'(maddr), 32'h40);
    reg_read(S_DLO);
    chk("R8 trig read", 32'(p_rdata), 32'(pat(32'h40) & 16'hFF));
    chk("R4 read step", 32'(maddr), 32'h41);
    idle(3);
    peek(S_DLO, v); chk("R8 refetch", 32'(v), 32'(pat(32'h41) & 16'hFF));
    reg_write(S_CTRL, 8'h81);
    idle(1);
    reg_read(S_DHI);
    chk("R8 hi-trig read", 32'(p_rdata), 32'(pat(32'h41) >> 8));
    chk("R5 read stride", 32'(maddr), 32'h61);
    idle(3);
    peek(S_DHI, v); chk("R8 hi refetch", 32'(v), 32'(pat(32'h61) >> 8));
  endtask

  task automatic t_collision();
    logic [7:0] v;
    reg_write(S_CTRL, 8'h80);
    set_addr(16'h0050);
    reg_write(S_DLO, 8'h77);
    chk("R9 write wins", 32'(p_we), 1);
    chk("R9 fetch held", 32'(p_re), 0);
    #1;
    chk("R9 fetch after", 32'(mre), 1);
    chk("R9 fetch addr", 32'(maddr), 32'h50);
    idle(2);
    peek(S_DLO, v); chk("R9 new lo seen", 32'(v), 32'h77);
    peek(S_DHI, v); chk("R9 old hi seen", 32'(v), 32'(pat(32'h50) >> 8));
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) ram[i] = pat(i);
    mrdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_byte_writes();
    t_word_hi_trig();
    t_strides();
    t_fmt();
    t_wrap();
    t_reads();
    t_collision();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule